// File: doc/BRIEF.md
# Per-Endpoint Transaction Status Recorder

This block holds a one-byte record per endpoint describing the outcome of the most recent transaction on that endpoint. It covers sixteen endpoints: the control OUT endpoint, the control IN endpoint and data endpoints 1 through 14. When a transaction finishes, the protocol engine raises a single-cycle event. The event carries the endpoint index, a 4-bit error code, a success flag and the data PID type (DATA0 or DATA1). Each event replaces the stored record for its endpoint.

A processor reads a record by issuing a one-byte read command. The response is a single status byte. Reading an endpoint consumes its record. If a second event lands before the processor reads the first one, the record is overwritten and a sticky overrun flag tells the processor that an earlier status was lost. Only a read of that endpoint clears the flag.

Top module: `ep_status_recorder`

## Requirements
- R1: A read command in the range 0xA0 to 0xAF selects endpoint index n = command & 0xF. Index 0 is control OUT, index 1 is control IN, and indices 2 to 15 are data endpoints 1 to 14. On the clock edge after the command is sampled, `rd_data_valid` is 1 for exactly one cycle and `rd_data` carries that endpoint's record.
- R2: A read command outside 0xA0 to 0xAF gives no response. `rd_data_valid` stays 0 and no record changes, including the consumed state.
- R3: After reset every record reads 0x00.
- R4: Every event on an endpoint writes its error code into bits 3:0 of that endpoint's record, replacing the previous code.
- R5: On an event with the success flag set, bit 6 takes the PID type (0 = DATA0, 1 = DATA1). On an event with the success flag clear, bit 6 keeps its previous value while bits 3:0 still update.
- R6: Bits 5:4 of every returned byte are 0.
- R7: An event on an endpoint whose record has been written and not yet read sets bit 7 (overrun).
- R8: A read of an endpoint clears its bit 7 and marks its record as consumed. The records of other endpoints are unchanged.
- R9: When an event and a read target the same endpoint in the same cycle, the read returns the record as it was before the event. Afterwards the record holds the new event's contents with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Transaction-complete event strobe |
| evt_ep | input | 4 | Endpoint index of the event |
| evt_err | input | 4 | Error code of the finished transaction |
| evt_ok | input | 1 | Transaction succeeded |
| evt_pid | input | 1 | Data PID of the packet (0 = DATA0, 1 = DATA1) |
| rd_valid | input | 1 | Read command strobe |
| rd_cmd | input | 8 | Read command code |
| rd_data_valid | output | 1 | Response byte is present |
| rd_data | output | 8 | Status byte of the selected endpoint (0 when no response) |

## Verification
The record path is driven with several event patterns:
- A single successful event followed by a read, which separates the error-code field from the PID bit.
- A failed event, which shows whether bit 6 is held or reloaded.
- Two back-to-back events before any read, which separates a consumed record from an overwritten one.

Reads at the first and last command codes and codes with a neighbouring high nibble (0x9x, 0xBx) show whether the decode boundaries are right. The bench then confirms that a rejected code left the consumed state untouched. An event colliding with a read of the same endpoint shows whether the response comes from the old or the new record and whether the overrun flag is raised.

// File: rtl/epsr_pkg.sv
package epsr_pkg;

    localparam int ERR_W = 4;

    typedef struct packed {
        logic             unread;   // overrun: record replaced before it was read
        logic             pid;      // PID type of last good packet
        logic [ERR_W-1:0] err;      // error code of last transaction
        logic             pending;  // record written and not yet consumed
    } rec_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } resp_t;

    function automatic logic [7:0] pack_rec(input rec_t r);
        return {r.unread, r.pid, 2'b00, r.err};
    endfunction

endpackage

// File: rtl/epsr_cmd_decode.sv
module epsr_cmd_decode #(
    parameter int         NUM_EP   = 16,
    parameter logic [7:0] CMD_BASE = 8'hA0
) (
    input  logic                      rd_valid,
    input  logic [7:0]                rd_cmd,
    output logic                      hit,
    output logic [$clog2(NUM_EP)-1:0] idx
);
    localparam int IDX_W = $clog2(NUM_EP);

    always_comb begin
        hit = rd_valid && (rd_cmd[7:IDX_W] == CMD_BASE[7:IDX_W]);
        idx = rd_cmd[IDX_W-1:0];
    end

endmodule

// File: rtl/epsr_slot.sv
module epsr_slot
    import epsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_hit,
    input  logic [ERR_W-1:0] evt_err,
    input  logic             evt_ok,
    input  logic             evt_pid,
    input  logic             rd_hit,
    output rec_t             rec_o
);
    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (rd_hit) begin
            rec_d.unread  = 1'b0;
            rec_d.pending = 1'b0;
        end
        if (evt_hit) begin
            if (rec_q.pending || rd_hit) begin
                rec_d.unread = 1'b1;
            end
            rec_d.pending = 1'b1;
            rec_d.err     = evt_err;
            if (evt_ok) begin
                rec_d.pid = evt_pid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec_o = rec_q;

    assert_err_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> rec_q.err == $past(evt_err));

    assert_fail_keeps_pid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && !evt_ok) |=> $stable(rec_q.pid));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && rec_q.pending) |=> rec_q.unread);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !evt_hit) |=> (!rec_q.unread && !rec_q.pending));

    assert_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && evt_hit) |=> (rec_q.unread && rec_q.pending));

endmodule

// File: rtl/ep_status_recorder.sv
module ep_status_recorder
    import epsr_pkg::*;
#(
    parameter int         NUM_EP   = 16,
    parameter logic [7:0] CMD_BASE = 8'hA0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_valid,
    input  logic [$clog2(NUM_EP)-1:0] evt_ep,
    input  logic [ERR_W-1:0]          evt_err,
    input  logic                      evt_ok,
    input  logic                      evt_pid,
    input  logic                      rd_valid,
    input  logic [7:0]                rd_cmd,
    output logic                      rd_data_valid,
    output logic [7:0]                rd_data
);
    localparam int IDX_W = $clog2(NUM_EP);

    logic             rd_hit;
    logic [IDX_W-1:0] rd_idx;
    rec_t             recs   [NUM_EP];
    logic [NUM_EP-1:0] slot_rd;
    logic [NUM_EP-1:0] slot_evt;

    epsr_cmd_decode #(
        .NUM_EP   (NUM_EP),
        .CMD_BASE (CMD_BASE)
    ) i_decode (
        .rd_valid (rd_valid),
        .rd_cmd   (rd_cmd),
        .hit      (rd_hit),
        .idx      (rd_idx)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
        assign slot_evt[g] = evt_valid && (evt_ep == IDX_W'(g));
        assign slot_rd[g]  = rd_hit && (rd_idx == IDX_W'(g));

        epsr_slot i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_hit (slot_evt[g]),
            .evt_err (evt_err),
            .evt_ok  (evt_ok),
            .evt_pid (evt_pid),
            .rd_hit  (slot_rd[g]),
            .rec_o   (recs[g])
        );
    end

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d.valid = rd_hit;
        resp_d.data  = rd_hit ? pack_rec(recs[rd_idx]) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rd_data_valid = resp_q.valid;
    assign rd_data       = resp_q.data;

    assert_one_slot_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_rd));

    assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_cmd[7:IDX_W] == CMD_BASE[7:IDX_W]) |=> rd_data_valid);

    assert_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_cmd[7:IDX_W] == CMD_BASE[7:IDX_W]) |=> !rd_data_valid);

    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5:4] == 2'b00);

endmodule

// File: tb/test_ep_status_recorder.sv
`timescale 1ns/1ps
module test_ep_status_recorder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [3:0] evt_ep = '0;
    logic [3:0] evt_err = '0;
    logic       evt_ok = 1'b0;
    logic       evt_pid = 1'b0;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_cmd = '0;
    logic       rd_data_valid;
    logic [7:0] rd_data;

    always #2 clk = ~clk;

    ep_status_recorder i_ep_status_recorder (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_valid     (evt_valid),
        .evt_ep        (evt_ep),
        .evt_err       (evt_err),
        .evt_ok        (evt_ok),
        .evt_pid       (evt_pid),
        .rd_valid      (rd_valid),
        .rd_cmd        (rd_cmd),
        .rd_data_valid (rd_data_valid),
        .rd_data       (rd_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    // reference model state, built from the requirements
    logic [3:0] m_err    [16];
    logic       m_pid    [16];
    logic       m_unread [16];
    logic       m_pend   [16];

    task automatic step(input logic ev, input int ep, input int err, input logic ok,
                        input logic pid, input logic rv, input logic [7:0] cmd,
                        input string tag);
        logic       hit;
        logic [3:0] ri;
        logic       coll;
        logic       oldpend;
        @(negedge clk);
        evt_valid = ev;
        evt_ep    = 4'(ep);
        evt_err   = 4'(err);
        evt_ok    = ok;
        evt_pid   = pid;
        rd_valid  = rv;
        rd_cmd    = cmd;
        hit = rv && (cmd[7:4] == 4'hA);
        ri  = cmd[3:0];
        if (hit) begin
            exp_q.push_back({1'b1, m_unread[ri], m_pid[ri], 2'b00, m_err[ri]});
        end else begin
            exp_q.push_back(9'h000);
        end
        tag_q.push_back(tag);
        coll    = hit && ev && (ri == 4'(ep));
        oldpend = ev ? m_pend[ep] : 1'b0;
        if (hit) begin
            m_unread[ri] = 1'b0;
            m_pend[ri]   = 1'b0;
        end
        if (ev) begin
            if (oldpend || coll) m_unread[ep] = 1'b1;
            m_pend[ep] = 1'b1;
            m_err[ep]  = 4'(err);
            if (ok) m_pid[ep] = pid;
        end
    endtask

    task automatic rd(input int ep, input string tag);
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 8'hA0 + 8'(ep), tag);
    endtask

    task automatic ev(input int ep, input int err, input logic ok, input logic pid, input string tag);
        step(1'b1, ep, err, ok, pid, 1'b0, 8'h00, tag);
    endtask

    // monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if ({rd_data_valid, rd_data} !== e) begin
                n_fail++;
                $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
                         t, rd_data_valid, rd_data, e[8], e[7:0]);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_err[i] = '0; m_pid[i] = 1'b0; m_unread[i] = 1'b0; m_pend[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3/R6/R1: all records zero after reset, every code answers
        for (int i = 0; i < 16; i++) rd(i, "R3 reset record");

        // R4/R5: successful event, DATA1
        ev(5, 3, 1'b1, 1'b1, "R4 event");
        rd(5, "R4 R5 good event read");
        // R5: failed event keeps pid, updates error
        ev(5, 9, 1'b0, 1'b0, "R5 event");
        rd(5, "R5 failed event read");

        // R7 then R8
        ev(0, 0, 1'b1, 1'b0, "R7 event");
        ev(0, 2, 1'b1, 1'b1, "R7 event");
        rd(0, "R7 overrun read");
        rd(0, "R8 cleared after read");

        // R8: other endpoints untouched
        ev(1, 1, 1'b1, 1'b0, "R8 event");
        ev(2, 5, 1'b1, 1'b0, "R8 event");
        ev(2, 5, 1'b1, 1'b1, "R8 event");
        rd(1, "R8 read ep index 1");
        rd(2, "R8 neighbour keeps overrun");

        // R2: rejected codes give nothing and consume nothing
        ev(3, 7, 1'b1, 1'b1, "R2 event");
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 8'hB3, "R2 code 0xB3");
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 8'h93, "R2 code 0x93");
        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 8'hFF, "R2 code 0xFF");
        ev(3, 6, 1'b1, 1'b0, "R2 event");
        rd(3, "R2 record still pending");

        // R9: collision
        ev(7, 4, 1'b1, 1'b1, "R9 event");
        step(1'b1, 7, 6, 1'b1, 1'b0, 1'b1, 8'hA7, "R9 collision returns old");
        rd(7, "R9 overrun after collision");
        rd(7, "R9 cleared");

        // R1: last code boundary
        ev(15, 15, 1'b1, 1'b1, "R1 event");
        rd(15, "R1 code 0xAF");
        rd(14, "R1 code 0xAE");

        step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 8'h00, "R1 idle");
        @(negedge clk);
        rd_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1: got %0d unchecked items, expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule